// File: doc/BRIEF.md
# Nine-bit UART receiver with address filtering

This block receives asynchronous serial frames on a multidrop line. In the two nine-bit modes a frame has eleven bits: a low start bit, eight data bits least significant first, a ninth bit, and a high stop bit. On a multidrop line a ninth bit of 1 marks an address frame. In the two eight-bit modes the frame has no ninth bit, and the stop bit is reported in its place. The line is oversampled by a baud tick that runs at sixteen times the bit rate. Each bit is taken from the sample in the middle of its bit period.

With the address filter enabled in a nine-bit mode, the node ignores all traffic until an address frame arrives whose byte equals the programmed node address. Software then clears the filter enable, takes the data frames that follow, and sets the filter enable again to wait for the next address. A stop bit sampled low sets a sticky framing-error flag.

Top module: `uart9_rx`

## Requirements
- R1: After reset, rx_data and rx_bit9 are 0, and ri and fe are 0.
- R2: In a nine-bit mode (mode[1]=1) with filt_en=0, a frame is received least significant bit first. rx_data takes the eight data bits, rx_bit9 takes the ninth bit, and ri is set. mode[0] does not affect the framing.
- R3: In an eight-bit mode (mode[1]=0), a frame is a start bit, eight data bits and a stop bit. rx_bit9 takes the stop bit value, and filt_en has no effect.
- R4: In a nine-bit mode with filt_en=1, a frame whose ninth bit is 1 and whose byte equals node_addr is accepted: rx_data and rx_bit9 are loaded and ri is set.
- R5: In a nine-bit mode with filt_en=1, a frame whose ninth bit is 0, or whose byte differs from node_addr, leaves rx_data, rx_bit9 and ri unchanged.
- R6: With filt_en=0, every complete frame is accepted, whatever its ninth bit.
- R7: A stop bit sampled as 0 sets fe, including on a frame the filter rejects. fe stays set until a cycle with fe_clr=1 clears it.
- R8: A low level on rxd that has returned high by the eighth tick after the first low sample is treated as a false start. It changes no output, and a later valid frame is still received.
- R9: While rx_en=0 in the idle state, the receiver does not start a frame, and its outputs do not change.
- R10: ri is set only by an accepted frame. It stays set until a cycle with ri_clr=1 clears it. A set from a completing frame takes priority over the clear.
- R11: Results update on the clock edge of the tick that samples the middle of the stop bit. Before that tick, a frame has not changed any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | One-cycle pulse at sixteen times the bit rate |
| rxd | input | 1 | Serial input, already synchronised, idles high |
| mode | input | 2 | Mode select; bit 1 set selects a nine-bit frame |
| rx_en | input | 1 | Receive enable |
| filt_en | input | 1 | Address filter enable (nine-bit modes only) |
| node_addr | input | 8 | Programmed node address |
| ri_clr | input | 1 | Clears ri |
| fe_clr | input | 1 | Clears fe |
| rx_data | output | 8 | Last accepted byte |
| rx_bit9 | output | 1 | Ninth bit, or the stop bit in eight-bit modes |
| ri | output | 1 | Receive interrupt flag |
| fe | output | 1 | Framing-error flag |

## Verification
The data, ninth bit and interrupt results are due one clock after the tick that samples the middle of the stop bit. That tick comes 8 + 16·N ticks after the first low sample, where N is the number of bits after the start bit. The bench holds every bit for a full sixteen ticks and adds a full bit time of idle high after the stop bit. It compares outputs only after that idle time, when no further update can come. For R11, a probe a quarter of the way into the stop bit confirms that nothing has changed early. Rejected, false-start and disabled cases are checked at the same point against the values held from before.

// File: rtl/uart9_rx.sv
module uart9_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic [1:0] mode,
  input  logic       rx_en,
  input  logic       filt_en,
  input  logic [7:0] node_addr,
  input  logic       ri_clr,
  input  logic       fe_clr,
  output logic [7:0] rx_data,
  output logic       rx_bit9,
  output logic       ri,
  output logic       fe
);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} state_t;

  state_t     st;
  logic [3:0] cnt;
  logic [3:0] bitn;
  logic [8:0] sh;
  logic       nine_q;

  wire [3:0] last_bit = nine_q ? 4'd8 : 4'd7;
  wire       done     = tick16 && (st == S_STOP) && (cnt == 4'd15);
  wire       addr_ok  = sh[8] && (sh[7:0] == node_addr);
  wire       accept   = done && (!(nine_q && filt_en) || addr_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      bitn   <= '0;
      sh     <= '0;
      nine_q <= 1'b0;
    end else if (tick16) begin
      case (st)
        S_IDLE:
          if (rx_en && !rxd) begin
            st     <= S_START;
            cnt    <= '0;
            nine_q <= mode[1];
          end
        S_START:
          if (cnt == 4'd7) begin
            st   <= rxd ? S_IDLE : S_DATA;
            cnt  <= '0;
            bitn <= '0;
          end else cnt <= cnt + 4'd1;
        S_DATA:
          if (cnt == 4'd15) begin
            cnt      <= '0;
            sh[bitn] <= rxd;
            bitn     <= bitn + 4'd1;
            if (bitn == last_bit) st <= S_STOP;
          end else cnt <= cnt + 4'd1;
        default:
          if (cnt == 4'd15) st <= S_IDLE;
          else cnt <= cnt + 4'd1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data <= '0;
      rx_bit9 <= 1'b0;
      ri      <= 1'b0;
      fe      <= 1'b0;
    end else begin
      if (accept) begin
        rx_data <= sh[7:0];
        rx_bit9 <= nine_q ? sh[8] : rxd;
        ri      <= 1'b1;
      end else if (ri_clr) ri <= 1'b0;
      if (done && !rxd) fe <= 1'b1;
      else if (fe_clr)  fe <= 1'b0;
    end
  end

  assert_ri_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ri) |-> $past(done));

  assert_filter_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ri) && $past(nine_q && filt_en)) |-> (rx_bit9 && rx_data == $past(node_addr)));

  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> ($stable(rx_data) && $stable(rx_bit9)));

  assert_fe_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fe && !fe_clr) |=> fe);

  assert_idle_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !rx_en) |=> (st == S_IDLE));

endmodule

// File: tb/uart9_rx_tb.sv
module uart9_rx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] mode = 2'b10;
  logic       rx_en = 1'b1;
  logic       filt_en = 1'b0;
  logic [7:0] node_addr = 8'h00;
  logic       ri_clr = 1'b0;
  logic       fe_clr = 1'b0;
  logic [7:0] rx_data;
  logic       rx_bit9, ri, fe;

  int tests = 0, fails = 0;
  bit done_flag = 0;
  logic [7:0] e_data = 0;
  logic e_b9 = 0, e_ri = 0, e_fe = 0;

  uart9_rx u_dut (.clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .mode(mode),
    .rx_en(rx_en), .filt_en(filt_en), .node_addr(node_addr), .ri_clr(ri_clr),
    .fe_clr(fe_clr), .rx_data(rx_data), .rx_bit9(rx_bit9), .ri(ri), .fe(fe));

  always #5 clk = ~clk;

  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      tc++;
      tick16 = (tc % 4 == 0);
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit f_accept(bit nine, bit filt, bit b9, logic [7:0] d, logic [7:0] a);
    return !(nine && filt) || (b9 && d == a);
  endfunction

  task automatic check_all(input string tag);
    check(tag, rx_data, e_data);
    check(tag, rx_bit9, e_b9);
    check(tag, ri, e_ri);
    check(tag, fe, e_fe);
  endtask

  task automatic hold_bit(input logic v);
    rxd = v;
    repeat (64) @(negedge clk);
  endtask

  task automatic send(input bit b9, input logic [7:0] d, input bit stopv, input bit probe);
    bit nine = mode[1];
    bit en = rx_en;
    hold_bit(1'b0);
    for (int i = 0; i < 8; i++) hold_bit(d[i]);
    if (nine) hold_bit(b9);
    rxd = stopv;
    repeat (16) @(negedge clk);
    if (probe) check("R11", ri, e_ri);
    repeat (48) @(negedge clk);
    hold_bit(1'b1);
    if (en) begin
      if (!stopv) e_fe = 1;
      if (f_accept(nine, filt_en, b9, d, node_addr)) begin
        e_data = d;
        e_b9 = nine ? b9 : stopv;
        e_ri = 1;
      end
    end
  endtask

  task automatic clr_ri();
    ri_clr = 1; @(negedge clk); ri_clr = 0; @(negedge clk);
    e_ri = 0;
  endtask

  task automatic clr_fe();
    fe_clr = 1; @(negedge clk); fe_clr = 0; @(negedge clk);
    e_fe = 0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1234abcd));
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1");

    mode = 2'b10; filt_en = 0;
    send(0, 8'hA5, 1, 0); check_all("R2");
    mode = 2'b11;
    send(1, 8'h3C, 1, 0); check_all("R6");

    mode = 2'b01; filt_en = 1; node_addr = 8'h77;
    send(0, 8'hC3, 1, 0); check_all("R3");

    mode = 2'b10; node_addr = 8'h5A; clr_ri();
    send(0, 8'h5A, 1, 0); check_all("R5");
    send(1, 8'h11, 1, 0); check_all("R5");
    send(1, 8'h5A, 1, 0); check_all("R4");
    filt_en = 0;
    send(0, 8'h99, 1, 0); check_all("R6");

    send(0, 8'h42, 0, 0); check_all("R7");
    send(0, 8'h43, 1, 0); check_all("R7");
    clr_fe(); check_all("R7");
    filt_en = 1;
    send(0, 8'h44, 0, 0); check_all("R7");
    clr_fe(); filt_en = 0;

    rxd = 0; repeat (16) @(negedge clk);
    rxd = 1; repeat (160) @(negedge clk);
    check_all("R8");
    send(1, 8'h81, 1, 0); check_all("R8");

    rx_en = 0;
    send(1, 8'hEE, 1, 0); check_all("R9");
    rx_en = 1;
    repeat (64) @(negedge clk);
    send(0, 8'h0F, 1, 0); check_all("R9");

    clr_ri(); check_all("R10");
    send(0, 8'hF0, 1, 1); check_all("R11");

    for (int k = 0; k < 40; k++) begin
      logic [7:0] d;
      bit b9;
      mode = 2'($urandom_range(0, 3));
      filt_en = 1'($urandom_range(0, 1));
      node_addr = 8'($urandom);
      d = ($urandom_range(0, 1) != 0) ? node_addr : 8'($urandom);
      b9 = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 3) == 0) clr_ri();
      if ($urandom_range(0, 3) == 0) clr_fe();
      send(b9, d, ($urandom_range(0, 7) != 0), 0);
      check_all(mode[1] ? (filt_en ? "R4" : "R6") : "R3");
    end
    finish_run();
  end
endmodule